// File: doc/BRIEF.md
# Two-Phase Self-Test Watchdog Monitor

This block supervises a self-test controller as it moves through two phases that always run in the same order. First the controller loads its configuration. Then it runs the tests. Each phase has its own watchdog. During loading, a watchdog with a fixed period of 1024 enabled ticks runs. Software cannot change that period. The only way to restart it is to write a defined key value to the key register, interleaved between the configuration writes. During execution, a second watchdog runs with a period taken from a writable period register.

If the loading watchdog expires, the block stops in a halted state, raises an abort output and sets a sticky loading-timeout flag. If the execution watchdog expires, the block sets a sticky execution-timeout flag, which can be inspected after the test ends. The execution watchdog stops counting once the test reports completion. Both flags stay set until they are cleared by writing one to their bit.

Each phase may use a different timing source. The block models this with one clock and a separate count enable for each watchdog. The self-test engines themselves sit outside this block.

Top module: `stest_wdog_mon`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), both timeout flags are 0 and `abort_o` is 0. The phase encoding is: 0 idle, 1 loading, 2 executing, 3 halted.
- R2: `cfg_start_i` is accepted only in idle or halted, and moves the block to loading. `exec_start_i` is accepted only in loading, and moves the block to executing. In idle, `exec_start_i` is ignored.
- R3: The loading watchdog expires on the 1024th enabled tick after loading starts or after the last refresh, if no refresh comes in between. At that same edge, `ld_tmo_o` is set and `phase_o` becomes halted.
- R4: A refresh happens only on a write to address 0 whose data equals `KEY_VAL` (default 32'hC3A5_0F96). A write of any other value to address 0, or of the key value to any other address, does not refresh. A refresh on the terminal tick prevents that expiry.
- R5: Configuration records take 17 cycles each. A key write after every 60 records keeps loading alive. A run of 61 records with no key write expires.
- R6: The loading watchdog advances only on cycles where `tick_ld_i` is 1.
- R7: Address 1, bits [15:0], holds the execution period P. Execution expires after P cycles where `tick_ex_i` is 1; a value of 0 acts as 1. On expiry, `ex_tmo_o` is set and `phase_o` returns to idle.
- R8: `exec_done_i` in the executing phase returns the block to idle and stops the execution watchdog. A done on the same edge as the expiry tick wins, and no flag is set.
- R9: Writing to address 2 clears `ld_tmo_o` when data bit 0 is 1, and clears `ex_tmo_o` when data bit 1 is 1. A flag set in the same cycle as its clear stays set.
- R10: `abort_o` is 1 exactly while the block is halted. A `cfg_start_i` clears `abort_o` and starts a new loading phase, and leaves `ld_tmo_o` unchanged.
- R11: The loading period cannot be altered by any register write. Writes to addresses 1, 2 and 3 during loading leave the 1024-tick expiry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_ld_i | input | 1 | Count enable for the loading watchdog |
| tick_ex_i | input | 1 | Count enable for the execution watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (4) | Register write address |
| wr_data_i | input | DATA_W (32) | Register write data |
| cfg_start_i | input | 1 | Start of configuration loading |
| exec_start_i | input | 1 | Start of test execution |
| exec_done_i | input | 1 | Test execution finished |
| phase_o | output | 2 | Current phase |
| ld_tmo_o | output | 1 | Sticky loading-timeout flag |
| ex_tmo_o | output | 1 | Sticky execution-timeout flag |
| abort_o | output | 1 | Abort, raised after a loading timeout |

## Verification
Suppose the loading counter is off by one, or a refresh is dropped or falsely accepted. Then `ld_tmo_o` and `abort_o` change on a different edge from the 1024th tick. The bench therefore samples one cycle before and one cycle after that edge. A wrong execution count, or a done that does not take priority, shows up as a premature, late or spurious `ex_tmo_o` within the programmed period. A phase register that takes an illegal transition shows up on `phase_o` at the next edge.

// File: rtl/stw_pkg.sv
package stw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_EXEC = 2'd2,
    PH_HALT = 2'd3
  } phase_e;

  localparam int unsigned A_KEY    = 0;
  localparam int unsigned A_PERIOD = 1;
  localparam int unsigned A_STAT   = 2;
endpackage

// File: rtl/stw_regs.sv
module stw_regs
  import stw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PER_W   = 16,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'hC3A5_0F96,
  parameter logic [PER_W-1:0]  PER_RST = 16'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ld_set_i,
  input  logic              ex_set_i,
  output logic              kick_o,
  output logic [PER_W-1:0]  period_o,
  output logic              ld_flag_o,
  output logic              ex_flag_o
);
  logic sel_key, sel_per, sel_stat;

  assign sel_key  = wr_en_i && (wr_addr_i == ADDR_W'(A_KEY));
  assign sel_per  = wr_en_i && (wr_addr_i == ADDR_W'(A_PERIOD));
  assign sel_stat = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));

  // exact match only
  assign kick_o = sel_key && (wr_data_i == KEY_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= PER_RST;
    end else if (sel_per) begin
      period_o <= wr_data_i[PER_W-1:0];
    end
  end

  // set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_flag_o <= 1'b0;
      ex_flag_o <= 1'b0;
    end else begin
      if (ld_set_i)                      ld_flag_o <= 1'b1;
      else if (sel_stat && wr_data_i[0]) ld_flag_o <= 1'b0;
      if (ex_set_i)                      ex_flag_o <= 1'b1;
      else if (sel_stat && wr_data_i[1]) ex_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stw_load_wdog.sv
module stw_load_wdog #(
  parameter int unsigned LD_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam logic [LD_W-1:0] LD_TERM = '1;

  logic [LD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i || (run_i && kick_i)) begin
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && tick_i && !kick_i && (cnt_q == LD_TERM);
endmodule

// File: rtl/stw_exec_wdog.sv
module stw_exec_wdog #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             done_i,
  output logic             expire_o
);
  logic [PER_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q <= PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= period_i;
    end else if (run_i && tick_i && !done_i && !last) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && tick_i && !done_i && last;
endmodule

// File: rtl/stest_wdog_mon.sv
module stest_wdog_mon
  import stw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PER_W   = 16,
  parameter int unsigned LD_W    = 10,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'hC3A5_0F96,
  parameter logic [PER_W-1:0]  PER_RST = 16'h0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_ld_i,
  input  logic              tick_ex_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cfg_start_i,
  input  logic              exec_start_i,
  input  logic              exec_done_i,
  output logic [1:0]        phase_o,
  output logic              ld_tmo_o,
  output logic              ex_tmo_o,
  output logic              abort_o
);
  phase_e           phase_q, phase_d;
  logic             kick, ld_exp, ex_exp, cfg_go, ex_go;
  logic             in_load, in_exec;
  logic [PER_W-1:0] period;

  assign in_load = (phase_q == PH_LOAD);
  assign in_exec = (phase_q == PH_EXEC);
  assign cfg_go  = cfg_start_i && (phase_q == PH_IDLE || phase_q == PH_HALT);
  // expiry outranks a late start of execution
  assign ex_go   = exec_start_i && in_load && !ld_exp;

  stw_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PER_W  (PER_W),
    .KEY_VAL(KEY_VAL),
    .PER_RST(PER_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ld_set_i (ld_exp),
    .ex_set_i (ex_exp),
    .kick_o   (kick),
    .period_o (period),
    .ld_flag_o(ld_tmo_o),
    .ex_flag_o(ex_tmo_o)
  );

  stw_load_wdog #(.LD_W(LD_W)) u_ld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_go),
    .run_i   (in_load),
    .tick_i  (tick_ld_i),
    .kick_i  (kick),
    .expire_o(ld_exp)
  );

  stw_exec_wdog #(.PER_W(PER_W)) u_ex (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ex_go),
    .period_i(period),
    .run_i   (in_exec),
    .tick_i  (tick_ex_i),
    .done_i  (exec_done_i),
    .expire_o(ex_exp)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (cfg_go) phase_d = PH_LOAD;
      PH_LOAD: begin
        if (ld_exp)     phase_d = PH_HALT;
        else if (ex_go) phase_d = PH_EXEC;
      end
      PH_EXEC: if (exec_done_i || ex_exp) phase_d = PH_IDLE;
      PH_HALT: if (cfg_go) phase_d = PH_LOAD;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign abort_o = (phase_q == PH_HALT);
endmodule

// File: rtl/stw_chk.sv
module stw_chk
  import stw_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              exec_done_i,
  input logic [1:0]        phase_o,
  input logic              ld_tmo_o,
  input logic              ex_tmo_o,
  input logic              abort_o
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));

  // R2
  exec_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_EXEC) |-> ($past(phase_o) == PH_LOAD || $past(phase_o) == PH_EXEC));

  // R3
  ld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_tmo_o) |-> ($past(phase_o) == PH_LOAD && phase_o == PH_HALT));

  // R7
  ex_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ex_tmo_o) |-> ($past(phase_o) == PH_EXEC && phase_o == PH_IDLE));

  // R8
  done_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_EXEC && exec_done_i) |=> (!$rose(ex_tmo_o) && phase_o == PH_IDLE));

  // R9
  ld_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ld_tmo_o) |-> $past(stat_wr && wr_data_i[0]));

  // R9
  ex_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ex_tmo_o) |-> $past(stat_wr && wr_data_i[1]));

  // R10
  abort_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> ld_tmo_o);

  // R10
  abort_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_o) |-> (phase_o == PH_LOAD));
endmodule

bind stest_wdog_mon stw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .exec_done_i(exec_done_i),
  .phase_o    (phase_o),
  .ld_tmo_o   (ld_tmo_o),
  .ex_tmo_o   (ex_tmo_o),
  .abort_o    (abort_o)
);

// File: tb/tb_stest_wdog_mon.sv
`timescale 1ns/1ps
module tb_stest_wdog_mon;
  localparam logic [31:0] KEY = 32'hC3A5_0F96;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_ld_i = 1'b1, tick_ex_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        cfg_start_i = 1'b0, exec_start_i = 1'b0, exec_done_i = 1'b0;
  logic [1:0]  phase_o;
  logic        ld_tmo_o, ex_tmo_o, abort_o;
  int          total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  stest_wdog_mon dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_ld_i(tick_ld_i), .tick_ex_i(tick_ex_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cfg_start_i(cfg_start_i), .exec_start_i(exec_start_i), .exec_done_i(exec_done_i),
    .phase_o(phase_o), .ld_tmo_o(ld_tmo_o), .ex_tmo_o(ex_tmo_o), .abort_o(abort_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    tick_ld_i = 1'b1; tick_ex_i = 1'b1; wr_en_i = 1'b0;
    cfg_start_i = 1'b0; exec_start_i = 1'b0; exec_done_i = 1'b0;
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
    idle(1);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_cfg();
    cfg_start_i = 1'b1; idle(1); cfg_start_i = 1'b0;
  endtask

  task automatic pulse_exec();
    exec_start_i = 1'b1; idle(1); exec_start_i = 1'b0;
  endtask

  task automatic pulse_done();
    exec_done_i = 1'b1; idle(1); exec_done_i = 1'b0;
  endtask

  task automatic record(int r);
    wr(3, 32'(r));
    idle(16);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 phase", phase_o, 0);
    chk("R1 ld_tmo", ld_tmo_o, 0);
    chk("R1 ex_tmo", ex_tmo_o, 0);
    chk("R1 abort", abort_o, 0);
    pulse_exec();
    chk("R2 exec_start in idle", phase_o, 0);
    pulse_cfg();
    chk("R2 cfg_start to load", phase_o, 1);
  endtask

  task automatic t_ld_exact();
    do_reset();
    pulse_cfg();
    idle(1023);
    chk("R3 before 1024", ld_tmo_o, 0);
    idle(1);
    chk("R3 at 1024", ld_tmo_o, 1);
    chk("R3 halted", phase_o, 3);
    chk("R10 abort", abort_o, 1);
  endtask

  task automatic t_key_edge();
    do_reset();
    pulse_cfg();
    idle(1023);
    wr(0, KEY);
    chk("R4 key on terminal tick", ld_tmo_o, 0);
    idle(1023);
    chk("R4 restart window", ld_tmo_o, 0);
    idle(1);
    chk("R4 expiry after refresh", ld_tmo_o, 1);
  endtask

  task automatic t_bad_key();
    do_reset();
    pulse_cfg();
    idle(499);
    wr(0, KEY ^ 32'h1);
    wr(3, KEY);
    wr(1, 32'h0);
    idle(521);
    chk("R4 R11 no refresh yet", ld_tmo_o, 0);
    idle(1);
    chk("R4 R11 expiry unchanged", ld_tmo_o, 1);
  endtask

  task automatic t_records();
    do_reset();
    pulse_cfg();
    for (int i = 0; i < 60; i++) record(i);
    wr(0, KEY);
    for (int i = 0; i < 60; i++) record(i);
    wr(0, KEY);
    chk("R5 60 records alive", ld_tmo_o, 0);
    chk("R5 still loading", phase_o, 1);
    pulse_exec();
    chk("R2 load to exec", phase_o, 2);
    do_reset();
    pulse_cfg();
    for (int i = 0; i < 61; i++) record(i);
    chk("R5 61 records expire", ld_tmo_o, 1);
    chk("R5 abort", abort_o, 1);
  endtask

  task automatic t_tick_gate();
    do_reset();
    pulse_cfg();
    idle(500);
    tick_ld_i = 1'b0;
    idle(300);
    tick_ld_i = 1'b1;
    idle(523);
    chk("R6 gated ticks", ld_tmo_o, 0);
    idle(1);
    chk("R6 expiry after gating", ld_tmo_o, 1);
  endtask

  task automatic t_exec_tmo();
    do_reset();
    pulse_cfg();
    wr(1, 32'd20);
    pulse_exec();
    idle(19);
    chk("R7 before period", ex_tmo_o, 0);
    chk("R7 executing", phase_o, 2);
    idle(1);
    chk("R7 expiry", ex_tmo_o, 1);
    chk("R7 back to idle", phase_o, 0);
    chk("R7 no abort", abort_o, 0);
    do_reset();
    pulse_cfg();
    wr(1, 32'd0);
    pulse_exec();
    idle(1);
    chk("R7 period zero", ex_tmo_o, 1);
    do_reset();
    pulse_cfg();
    wr(1, 32'd10);
    pulse_exec();
    tick_ex_i = 1'b0;
    idle(50);
    chk("R7 gated no expiry", ex_tmo_o, 0);
    tick_ex_i = 1'b1;
    idle(9);
    chk("R7 gated before", ex_tmo_o, 0);
    idle(1);
    chk("R7 gated expiry", ex_tmo_o, 1);
  endtask

  task automatic t_exec_done();
    do_reset();
    pulse_cfg();
    wr(1, 32'd20);
    pulse_exec();
    idle(5);
    pulse_done();
    chk("R8 done to idle", phase_o, 0);
    idle(30);
    chk("R8 stopped", ex_tmo_o, 0);
    do_reset();
    pulse_cfg();
    wr(1, 32'd20);
    pulse_exec();
    idle(19);
    pulse_done();
    chk("R8 done wins same edge", ex_tmo_o, 0);
    chk("R8 idle", phase_o, 0);
  endtask

  task automatic t_w1c();
    do_reset();
    pulse_cfg();
    idle(1024);
    chk("R9 ld set", ld_tmo_o, 1);
    pulse_cfg();
    chk("R10 abort cleared", abort_o, 0);
    chk("R10 reload", phase_o, 1);
    chk("R10 flag kept", ld_tmo_o, 1);
    wr(1, 32'd1);
    exec_start_i = 1'b1; idle(1); exec_start_i = 1'b0;
    wr(2, 32'h2);
    chk("R9 set beats clear", ex_tmo_o, 1);
    wr(2, 32'h0);
    chk("R9 zero write ld", ld_tmo_o, 1);
    wr(2, 32'h1);
    chk("R9 clear ld", ld_tmo_o, 0);
    chk("R9 ex untouched", ex_tmo_o, 1);
    wr(2, 32'h2);
    chk("R9 clear ex", ex_tmo_o, 0);
  endtask

  initial begin
    t_reset();
    t_ld_exact();
    t_key_edge();
    t_bad_key();
    t_records();
    t_tick_gate();
    t_exec_tmo();
    t_exec_done();
    t_w1c();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule